// File: doc/BRIEF.md
# Reorder Buffer with Multi-Cycle Squash Walk

This block is a circular in-order tracking buffer for an out-of-order core. Each dispatched instruction takes one slot at the tail. A slot holds the instruction's sequence number, its PC and its following PC, plus a completed mark and a squashed mark. The oldest slot leaves from the head, one per cycle, once it has been completed or squashed. Execution units set the completed mark through a writeback port, which addresses the slot by the index that was handed out when the slot was allocated.

A squash request names a sequence number. Every tracked instruction with a larger sequence number must be cancelled. The buffer does not drop those slots at once. It walks backward from the youngest slot, marks at most a fixed number of slots per cycle, and keeps its position in a register so the walk can continue over later cycles. Marked slots stay in place until they drain through the head. The tail pointer therefore never moves because of a squash. A done flag tells the front end when the walk has finished.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `occ_empty`=1, `occ_full`=0, `free_cnt`=DEPTH, `sq_done`=1 and `ret_valid`=0.
- R2: `occ_full` is 1 exactly when DEPTH slots are occupied. `occ_empty` is 1 exactly when none are occupied. `free_cnt` always equals DEPTH minus the occupancy.
- R3: When `ins_valid` is high, the new instruction is written at the tail slot, whose index `ins_slot` shows in that cycle. From the next cycle `tail_seq`/`tail_pc` show the youngest instruction. Inserting while `occ_full` is high is a protocol error.
- R4: A `wb_valid` pulse sets the completed mark of slot `wb_slot`. Completing a slot that is not the head causes no retirement.
- R5: Slots retire strictly oldest first, at most one per cycle. The head retires when it is valid and either completed or squashed. `ret_valid` is high in that cycle, with `ret_seq`, `ret_pc` and `ret_squashed` describing the slot.
- R6: An insert and a retirement in the same cycle leave the occupancy unchanged.
- R7: After a squash request with sequence number T, every slot whose sequence number is greater than T gets its squashed mark, and no other slot does. Marking starts with the youngest slot and moves toward the head, with at most SQ_WIDTH slots per cycle.
- R8: `sq_done` goes low in the cycle after an accepted request. It goes high again after the walk meets a slot with sequence number not greater than T, or after it has covered every occupied slot. The walk takes N/SQ_WIDTH+1 cycles when it stops at an older slot (N being the number of slots marked), takes ceil(N/SQ_WIDTH) cycles when every occupied slot is marked, and takes 1 cycle when the buffer is empty.
- R9: While a walk is in progress, no slot retires and the head and tail pointers hold. Occupancy stays the same through the walk.
- R10: A squash request that arrives during a walk is ignored when its sequence number is not smaller than the current target. A smaller one restarts the walk from the youngest slot with the new target.
- R11: `head_seq`, `head_pc` and `head_npc` describe the oldest slot. `head_ready` is 1 when that slot is valid and completed. These head values have no meaning while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Allocate a slot for a new instruction |
| ins_seq | input | SEQ_W | Sequence number of the new instruction |
| ins_pc | input | PC_W | PC of the new instruction |
| ins_npc | input | PC_W | Following PC of the new instruction |
| ins_slot | output | IDX_W | Slot index the next insert will take |
| wb_valid | input | 1 | Mark a slot completed |
| wb_slot | input | IDX_W | Slot index to complete |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash target; younger instructions are cancelled |
| sq_done | output | 1 | High when no squash walk is in progress |
| ret_valid | output | 1 | Head slot leaves this cycle |
| ret_seq | output | SEQ_W | Sequence number of the retiring slot |
| ret_pc | output | PC_W | PC of the retiring slot |
| ret_squashed | output | 1 | Retiring slot was cancelled |
| head_seq | output | SEQ_W | Sequence number of the oldest slot |
| head_pc | output | PC_W | PC of the oldest slot |
| head_npc | output | PC_W | Following PC of the oldest slot |
| head_ready | output | 1 | Oldest slot is valid and completed |
| tail_seq | output | SEQ_W | Sequence number of the youngest slot |
| tail_pc | output | PC_W | PC of the youngest slot |
| occ_full | output | 1 | All slots occupied |
| occ_empty | output | 1 | No slot occupied |
| free_cnt | output | CNT_W | Number of unoccupied slots |

## Verification
The walk is exercised with several target positions. One target cancels part of a full buffer. One cancels every occupied slot. One is issued on an empty buffer. Each of the three stop conditions leads to a different cycle count on `sq_done`, which also shows whether the per-cycle limit holds. Overlapping requests come in two forms. A younger second request would leave some slots uncancelled if it were wrongly accepted. An older second request must restart the walk and lengthen it by a known amount. The scoreboard compares the retire stream against a model of the slots, so a missing or wrong squashed mark shows up as a mismatch on `ret_squashed` or as an entry that never drains.

// File: rtl/reorder_buf_pkg.sv
package reorder_buf_pkg;

    // Ring index one step older (backward) with wrap at n.
    function automatic int unsigned ring_prev(input int unsigned p, input int unsigned n);
        return (p == 0) ? n - 1 : p - 1;
    endfunction

    // Ring index one step younger (forward) with wrap at n.
    function automatic int unsigned ring_next(input int unsigned p, input int unsigned n);
        return (p == n - 1) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/rb_occupancy.sv
module rb_occupancy #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [CNT_W-1:0] count_next,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] free
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (push && !pop) cnt_d = cnt_q + 1'b1;
        else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_next = cnt_d;
    assign full       = (cnt_q == CNT_W'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign free       = CNT_W'(DEPTH) - cnt_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/rb_walker.sv
module rb_walker
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int SQ_WIDTH = 2,
    parameter int SEQ_W    = 16,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic [SEQ_W-1:0]            req_seq,
    input  logic [IDX_W-1:0]            youngest_next,
    input  logic [CNT_W-1:0]            occ_next,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seqs,
    output logic                        busy,
    output logic [DEPTH-1:0]            mark
);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] ptr;
        logic [CNT_W-1:0] left;
        logic [SEQ_W-1:0] target;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  accept;

    always_comb begin
        logic [IDX_W-1:0] p;
        logic [CNT_W-1:0] l;
        logic             go;

        walk_d = walk_q;
        mark   = '0;
        p      = walk_q.ptr;
        l      = walk_q.left;
        go     = walk_q.active;

        for (int k = 0; k < SQ_WIDTH; k++) begin
            if (go) begin
                if (l == '0) begin
                    go = 1'b0;
                end else if (seqs[p] > walk_q.target) begin
                    mark[p] = 1'b1;
                    p       = IDX_W'(ring_prev(32'(p), DEPTH));
                    l       = l - 1'b1;
                end else begin
                    go = 1'b0;
                end
            end
        end

        if (walk_q.active) begin
            walk_d.ptr    = p;
            walk_d.left   = l;
            walk_d.active = go && (l != '0);
        end

        accept = req && (!walk_q.active || (req_seq < walk_q.target));
        if (accept) begin
            walk_d.active = 1'b1;
            walk_d.ptr    = youngest_next;
            walk_d.left   = occ_next;
            walk_d.target = req_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign busy = walk_q.active;

    // R7
    mark_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark) <= SQ_WIDTH);

    // R10
    younger_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req && (req_seq >= walk_q.target)) |=> (walk_q.target == $past(walk_q.target)));

    // R10
    older_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req && (req_seq < walk_q.target)) |=> (busy && walk_q.target == $past(req_seq)));

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int SQ_WIDTH = 2,
    parameter int SEQ_W    = 16,
    parameter int PC_W     = 32,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [PC_W-1:0]  ins_npc,
    output logic [IDX_W-1:0] ins_slot,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_slot,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             sq_done,
    output logic             ret_valid,
    output logic [SEQ_W-1:0] ret_seq,
    output logic [PC_W-1:0]  ret_pc,
    output logic             ret_squashed,
    output logic [SEQ_W-1:0] head_seq,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic             head_ready,
    output logic [SEQ_W-1:0] tail_seq,
    output logic [PC_W-1:0]  tail_pc,
    output logic             occ_full,
    output logic             occ_empty,
    output logic [CNT_W-1:0] free_cnt
);

    typedef struct packed {
        logic             valid;
        logic             done;
        logic             squashed;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slots;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  tail;
    } buf_t;

    buf_t                        st_d, st_q;
    slot_t                       hd, tl;
    logic                        pop;
    logic                        walk_busy;
    logic [DEPTH-1:0]            mark;
    logic [DEPTH-1:0][SEQ_W-1:0] seqs;
    logic [IDX_W-1:0]            youngest_next;
    logic [CNT_W-1:0]            occ_next;

    assign hd  = st_q.slots[st_q.head];
    assign tl  = st_q.slots[IDX_W'(ring_prev(32'(st_q.tail), DEPTH))];
    assign pop = !walk_busy && hd.valid && (hd.done || hd.squashed);

    // Youngest slot after this cycle's insert; independent of the walk result.
    assign youngest_next = ins_valid ? st_q.tail : IDX_W'(ring_prev(32'(st_q.tail), DEPTH));

    always_comb begin
        for (int i = 0; i < DEPTH; i++) seqs[i] = st_q.slots[i].seq;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (mark[i]) st_d.slots[i].squashed = 1'b1;
        end
        if (wb_valid) st_d.slots[wb_slot].done = 1'b1;
        if (pop) begin
            st_d.slots[st_q.head].valid = 1'b0;
            st_d.head = IDX_W'(ring_next(32'(st_q.head), DEPTH));
        end
        if (ins_valid) begin
            st_d.slots[st_q.tail].valid    = 1'b1;
            st_d.slots[st_q.tail].done     = 1'b0;
            st_d.slots[st_q.tail].squashed = 1'b0;
            st_d.slots[st_q.tail].seq      = ins_seq;
            st_d.slots[st_q.tail].pc       = ins_pc;
            st_d.slots[st_q.tail].npc      = ins_npc;
            st_d.tail = IDX_W'(ring_next(32'(st_q.tail), DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rb_occupancy #(.DEPTH(DEPTH)) occ_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ins_valid),
        .pop        (pop),
        .count_next (occ_next),
        .full       (occ_full),
        .empty      (occ_empty),
        .free       (free_cnt)
    );

    rb_walker #(.DEPTH(DEPTH), .SQ_WIDTH(SQ_WIDTH), .SEQ_W(SEQ_W)) walk_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (sq_valid),
        .req_seq       (sq_seq),
        .youngest_next (youngest_next),
        .occ_next      (occ_next),
        .seqs          (seqs),
        .busy          (walk_busy),
        .mark          (mark)
    );

    assign ins_slot     = st_q.tail;
    assign sq_done      = !walk_busy;
    assign ret_valid    = pop;
    assign ret_seq      = hd.seq;
    assign ret_pc       = hd.pc;
    assign ret_squashed = hd.squashed;
    assign head_seq     = hd.seq;
    assign head_pc      = hd.pc;
    assign head_npc     = hd.npc;
    assign head_ready   = hd.valid && hd.done;
    assign tail_seq     = tl.seq;
    assign tail_pc      = tl.pc;

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |=> $stable(st_q.head));

    // R9
    walk_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_busy |-> !ins_valid);

    // R5
    retire_slot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> !occ_empty);

endmodule

// File: tb/reorder_buf_tb_top.sv
`timescale 1ns/1ps
module reorder_buf_tb_top;

    localparam int DEPTH = 8;
    localparam int SQW   = 2;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             ins_valid;
    logic [SEQ_W-1:0] ins_seq;
    logic [PC_W-1:0]  ins_pc, ins_npc;
    logic [IDX_W-1:0] ins_slot;
    logic             wb_valid;
    logic [IDX_W-1:0] wb_slot;
    logic             sq_valid;
    logic [SEQ_W-1:0] sq_seq;
    logic             sq_done;
    logic             ret_valid;
    logic [SEQ_W-1:0] ret_seq;
    logic [PC_W-1:0]  ret_pc;
    logic             ret_squashed;
    logic [SEQ_W-1:0] head_seq;
    logic [PC_W-1:0]  head_pc, head_npc;
    logic             head_ready;
    logic [SEQ_W-1:0] tail_seq;
    logic [PC_W-1:0]  tail_pc;
    logic             occ_full, occ_empty;
    logic [CNT_W-1:0] free_cnt;

    reorder_buf #(.DEPTH(DEPTH), .SQ_WIDTH(SQW), .SEQ_W(SEQ_W), .PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_npc(ins_npc),
        .ins_slot(ins_slot),
        .wb_valid(wb_valid), .wb_slot(wb_slot),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_done(sq_done),
        .ret_valid(ret_valid), .ret_seq(ret_seq), .ret_pc(ret_pc), .ret_squashed(ret_squashed),
        .head_seq(head_seq), .head_pc(head_pc), .head_npc(head_npc), .head_ready(head_ready),
        .tail_seq(tail_seq), .tail_pc(tail_pc),
        .occ_full(occ_full), .occ_empty(occ_empty), .free_cnt(free_cnt)
    );

    typedef struct {
        int unsigned seq;
        int unsigned slot;
        bit          sq;
    } item_t;

    item_t sb_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;

    function automatic int unsigned pc_of(input int unsigned s);
        return 32'h1000 + s * 4;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic ins(input int unsigned s);
        item_t it;
        @(negedge clk);
        ins_valid = 1'b1;
        ins_seq   = SEQ_W'(s);
        ins_pc    = pc_of(s);
        ins_npc   = pc_of(s) + 4;
        it.seq = s; it.slot = ins_slot; it.sq = 1'b0;
        sb_q.push_back(it);
        @(posedge clk); #1;
        ins_valid = 1'b0;
    endtask

    task automatic wb(input int unsigned s);
        @(negedge clk);
        foreach (sb_q[i]) if (sb_q[i].seq == s) wb_slot = IDX_W'(sb_q[i].slot);
        wb_valid = 1'b1;
        @(posedge clk); #1;
        wb_valid = 1'b0;
    endtask

    // Issue a squash request; apply=1 updates the model as if it were accepted.
    task automatic sq_pulse(input int unsigned t, input bit apply, input bit with_wb,
                            input int unsigned wb_s);
        @(negedge clk);
        sq_valid = 1'b1;
        sq_seq   = SEQ_W'(t);
        if (apply) foreach (sb_q[i]) if (sb_q[i].seq > t) sb_q[i].sq = 1'b1;
        if (with_wb) begin
            foreach (sb_q[i]) if (sb_q[i].seq == wb_s) wb_slot = IDX_W'(sb_q[i].slot);
            wb_valid = 1'b1;
        end
        @(posedge clk); #1;
        sq_valid = 1'b0;
        wb_valid = 1'b0;
    endtask

    // Count busy cycles; no retirement may occur while busy (R9).
    task automatic wait_walk(output int cyc);
        cyc = 0;
        forever begin
            @(negedge clk);
            if (sq_done) break;
            cyc++;
            check(!ret_valid, "R9", "retire during walk", ret_valid, 0);
            if (cyc > 100) break;
        end
    endtask

    // Scoreboard monitor: each retirement must match the oldest model entry.
    always @(negedge clk) begin
        if (rst_n && ret_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R5", "unexpected retire seq", ret_seq, -1);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(ret_seq == SEQ_W'(it.seq), "R5", "retire order seq", ret_seq, it.seq);
                check(ret_pc == pc_of(it.seq), "R5", "retire pc", ret_pc, pc_of(it.seq));
                check(ret_squashed == it.sq, "R7", "squashed mark", ret_squashed, it.sq);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        rst_n = 1'b0; ins_valid = 1'b0; ins_seq = '0; ins_pc = '0; ins_npc = '0;
        wb_valid = 1'b0; wb_slot = '0; sq_valid = 1'b0; sq_seq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        check(occ_empty == 1'b1, "R1", "empty", occ_empty, 1);
        check(occ_full == 1'b0, "R1", "full", occ_full, 0);
        check(free_cnt == DEPTH, "R1", "free", free_cnt, DEPTH);
        check(sq_done == 1'b1, "R1", "sq_done", sq_done, 1);
        check(ret_valid == 1'b0, "R1", "ret_valid", ret_valid, 0);

        // R3 / R11 / R2 basic insert
        ins(10); ins(11); ins(12); settle();
        check(free_cnt == 5, "R2", "free after 3", free_cnt, 5);
        check(occ_empty == 1'b0, "R2", "empty after 3", occ_empty, 0);
        check(tail_seq == 12, "R3", "tail seq", tail_seq, 12);
        check(tail_pc == pc_of(12), "R3", "tail pc", tail_pc, pc_of(12));
        check(head_seq == 10, "R11", "head seq", head_seq, 10);
        check(head_pc == pc_of(10), "R11", "head pc", head_pc, pc_of(10));
        check(head_npc == pc_of(10) + 4, "R11", "head npc", head_npc, pc_of(10) + 4);
        check(head_ready == 1'b0, "R11", "head ready", head_ready, 0);

        // R4 completing a non-head slot retires nothing
        wb(11); settle(); settle();
        check(free_cnt == 5, "R4", "free after non-head wb", free_cnt, 5);
        check(head_seq == 10, "R4", "head unchanged", head_seq, 10);
        wb(10); repeat (4) settle();
        check(free_cnt == 7, "R5", "free after in-order retire", free_cnt, 7);
        check(head_seq == 12, "R5", "head after retire", head_seq, 12);

        // fill to DEPTH-1
        for (int s = 13; s <= 18; s++) ins(s);
        settle();
        check(free_cnt == 1, "R2", "free at depth-1", free_cnt, 1);
        check(occ_full == 1'b0, "R2", "not yet full", occ_full, 0);

        // R6 insert and retire together
        wb(12); ins(19); settle();
        check(free_cnt == 1, "R6", "free with push+pop", free_cnt, 1);
        check(head_seq == 13, "R6", "head after push+pop", head_seq, 13);
        ins(20); settle();
        check(occ_full == 1'b1, "R2", "full", occ_full, 1);
        check(free_cnt == 0, "R2", "free when full", free_cnt, 0);
        check(tail_seq == 20, "R3", "tail when full", tail_seq, 20);

        // R7 / R8 / R9 partial squash of full buffer: 5 marked -> 3 cycles
        sq_pulse(15, 1'b1, 1'b1, 13);
        wait_walk(cyc);
        check(cyc == 3, "R8", "walk cycles partial", cyc, 3);
        check(free_cnt == 0, "R9", "occupancy through walk", free_cnt, 0);
        check(tail_seq == 20, "R9", "tail held", tail_seq, 20);
        check(head_seq == 13, "R9", "head held", head_seq, 13);
        wb(14); wb(15); repeat (10) settle();
        check(occ_empty == 1'b1, "R5", "drained after squash", occ_empty, 1);
        check(sb_q.size() == 0, "R7", "model drained", sb_q.size(), 0);

        // R10 younger request during walk is ignored
        for (int s = 30; s <= 37; s++) ins(s);
        settle();
        check(occ_full == 1'b1, "R2", "full again", occ_full, 1);
        sq_pulse(30, 1'b1, 1'b0, 0);
        sq_pulse(35, 1'b0, 1'b0, 0);
        wait_walk(cyc);
        check(cyc + 1 == 4, "R10", "walk cycles with ignored req", cyc + 1, 4);
        wb(30); repeat (12) settle();
        check(occ_empty == 1'b1, "R10", "all younger slots squashed", occ_empty, 1);
        check(sb_q.size() == 0, "R10", "model drained", sb_q.size(), 0);

        // R10 older request restarts the walk
        for (int s = 40; s <= 45; s++) ins(s);
        sq_pulse(43, 1'b1, 1'b0, 0);
        sq_pulse(40, 1'b1, 1'b0, 0);
        wait_walk(cyc);
        check(cyc + 1 == 4, "R10", "walk cycles after restart", cyc + 1, 4);
        wb(40); repeat (10) settle();
        check(occ_empty == 1'b1, "R10", "drained after restart", occ_empty, 1);
        check(sb_q.size() == 0, "R10", "model drained restart", sb_q.size(), 0);

        // R8 squash of empty buffer
        sq_pulse(5, 1'b1, 1'b0, 0);
        wait_walk(cyc);
        check(cyc == 1, "R8", "walk cycles empty", cyc, 1);

        // R7 / R8 every occupied slot squashed: 4 slots -> 2 cycles
        for (int s = 50; s <= 53; s++) ins(s);
        sq_pulse(49, 1'b1, 1'b0, 0);
        wait_walk(cyc);
        check(cyc == 2, "R8", "walk cycles all marked", cyc, 2);
        repeat (8) settle();
        check(occ_empty == 1'b1, "R5", "squashed slots drain uncompleted", occ_empty, 1);
        check(free_cnt == DEPTH, "R2", "free at end", free_cnt, DEPTH);
        check(sb_q.size() == 0, "R7", "model empty at end", sb_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule